// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog for a small 8-bit microcontroller. It listens to the core's special-function-register write bus. It does nothing after reset. Software arms it by writing a two-byte key to one register address: 0x1E, then 0xE1. Once armed, a 14-bit counter steps forward on each machine-cycle strobe. Software must keep writing the same key pair so the counter never reaches its top value. Nothing written by software can turn the watchdog off again.

If the counter reaches its top value, the block raises a reset output for a fixed number of clocks. During that pulse the block holds itself disarmed with the counter at zero. When the pulse ends, the watchdog stays disarmed until software writes the key again. The key register is write-only, so the counter value never appears on the bus.

Top module: `seq_watchdog`

## Requirements
- R1: While `hwReset` is high, and on the clock after it is released, `wdtEnabled` and `wdtRstOut` are both low.
- R2: Writing 0x1E and then 0xE1 to SFR address 0xA6 arms the watchdog, and `wdtEnabled` goes high on the clock after the 0xE1 write.
- R3: A one-deep key flag controls the sequence. A write of 0x1E to 0xA6 sets it. A write of 0xE1 to 0xA6 completes the key only when the flag is set. Any other byte written to 0xA6 (0xE1 included) clears the flag. Writes to any other address leave the flag as it was.
- R4: While armed, the 14-bit counter starts from zero and advances by one only in cycles where `mcStrobe` is high.
- R5: When the armed counter holds 0x3FFF, the next clock edge starts the reset pulse. With a strobe in every cycle after arming, `wdtRstOut` is first high after the 16384th such cycle.
- R6: `wdtRstOut` stays high for exactly PULSE_LEN clocks (default 96). During the pulse `wdtEnabled` is low and key writes are ignored. Afterwards the watchdog stays disarmed and raises no further pulse.
- R7: While armed, a completed key clears the counter. A key completed one strobe short of the top value therefore prevents the pulse.
- R8: No SFR write of any value to any address disarms an armed watchdog.
- R9: Raising `hwReset` during a reset pulse ends the pulse on the next clock and leaves the block disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hwReset | input | 1 | Synchronous active-high hardware reset |
| mcStrobe | input | 1 | One-clock strobe, once per machine cycle |
| sfrWe | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR write address |
| sfrWdata | input | 8 | SFR write data |
| wdtRstOut | output | 1 | Reset pulse produced on overflow |
| wdtEnabled | output | 1 | High while the watchdog is armed |

## Verification
The bench targets these sequence corner cases:
- a lone 0xE1;
- a 0x1E followed by a foreign byte at the key address;
- a 0x1E followed by a write to some other address, then 0xE1.

A design that ignored write ordering, or that cleared the flag on foreign addresses, would arm when it should not, or fail to arm when it should.

The bench also probes the edge of the count:
- a key that lands exactly one strobe before 0x3FFF must prevent the pulse;
- an unserviced run must pulse after exactly 16384 strobes.

An off-by-one in the compare or in the clear priority shifts or suppresses the pulse.

Key writes during the pulse and a hardware reset in the middle of the pulse expose designs that re-arm early or let the pulse run on.

// File: rtl/seq_watchdog_pkg.sv
package seq_watchdog_pkg;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } dpStrobe_t;

  localparam logic [7:0] DEF_KEY_ADDR   = 8'hA6;
  localparam logic [7:0] DEF_KEY_FIRST  = 8'h1E;
  localparam logic [7:0] DEF_KEY_SECOND = 8'hE1;

endpackage

// File: rtl/seq_watchdog_dp.sv
module seq_watchdog_dp
  import seq_watchdog_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  dpStrobe_t        strb,
  output logic [CNT_W-1:0] countOut,
  output logic             atMax
);

  logic [CNT_W-1:0] count;

  // clear has priority over advance
  always_ff @(posedge clk) begin
    if (strb.clear)        count <= '0;
    else if (strb.advance) count <= count + 1'b1;
  end

  assign atMax    = &count;
  assign countOut = count;

endmodule

// File: rtl/seq_watchdog_ctrl.sv
module seq_watchdog_ctrl
  import seq_watchdog_pkg::*;
#(
  parameter logic [7:0] KEY_ADDR   = DEF_KEY_ADDR,
  parameter logic [7:0] KEY_FIRST  = DEF_KEY_FIRST,
  parameter logic [7:0] KEY_SECOND = DEF_KEY_SECOND,
  parameter int         PULSE_LEN  = 96
) (
  input  logic       clk,
  input  logic       hwReset,
  input  logic       mcStrobe,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  input  logic       atMax,
  output dpStrobe_t  strb,
  output logic       enabled,
  output logic       pulseOn
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);

  logic          armFlag;
  logic [PW-1:0] pulseCnt;
  logic          keyHit, firstKey, secondKey, overflow;

  assign keyHit    = sfrWe && (sfrAddr == KEY_ADDR);
  assign firstKey  = keyHit && (sfrWdata == KEY_FIRST);
  assign secondKey = keyHit && (sfrWdata == KEY_SECOND) && armFlag && !pulseOn;
  assign pulseOn   = (pulseCnt != '0);
  assign overflow  = enabled && atMax;

  always_ff @(posedge clk) begin
    if (hwReset) begin
      enabled  <= 1'b0;
      armFlag  <= 1'b0;
      pulseCnt <= '0;
    end else if (pulseOn) begin
      pulseCnt <= pulseCnt - 1'b1;
      enabled  <= 1'b0;
      armFlag  <= 1'b0;
    end else if (overflow) begin
      pulseCnt <= PULSE_INIT;
      enabled  <= 1'b0;
      armFlag  <= 1'b0;
    end else begin
      if (keyHit)    armFlag <= firstKey;
      if (secondKey) enabled <= 1'b1;
    end
  end

  always_comb begin
    strb.clear   = hwReset || !enabled || pulseOn || overflow || secondKey;
    strb.advance = enabled && mcStrobe;
  end

endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import seq_watchdog_pkg::*;
#(
  parameter int         CNT_W      = 14,
  parameter int         PULSE_LEN  = 96,
  parameter logic [7:0] KEY_ADDR   = DEF_KEY_ADDR,
  parameter logic [7:0] KEY_FIRST  = DEF_KEY_FIRST,
  parameter logic [7:0] KEY_SECOND = DEF_KEY_SECOND
) (
  input  logic       clk,
  input  logic       hwReset,
  input  logic       mcStrobe,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  output logic       wdtRstOut,
  output logic       wdtEnabled
);

  dpStrobe_t        strb;
  logic             atMax;
  logic [CNT_W-1:0] countNow;

  seq_watchdog_ctrl #(
    .KEY_ADDR(KEY_ADDR), .KEY_FIRST(KEY_FIRST),
    .KEY_SECOND(KEY_SECOND), .PULSE_LEN(PULSE_LEN)
  ) u_ctrl (
    .clk(clk), .hwReset(hwReset), .mcStrobe(mcStrobe),
    .sfrWe(sfrWe), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .atMax(atMax), .strb(strb), .enabled(wdtEnabled), .pulseOn(wdtRstOut)
  );

  seq_watchdog_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .strb(strb), .countOut(countNow), .atMax(atMax)
  );

endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk #(
  parameter int         CNT_W      = 14,
  parameter logic [7:0] KEY_ADDR   = 8'hA6,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input logic             clk,
  input logic             hwReset,
  input logic             mcStrobe,
  input logic             sfrWe,
  input logic [7:0]       sfrAddr,
  input logic [7:0]       sfrWdata,
  input logic             wdtRstOut,
  input logic             wdtEnabled,
  input logic [CNT_W-1:0] countNow
);

  logic keyWr;
  assign keyWr = sfrWe && (sfrAddr == KEY_ADDR);

  // R1: the cycle after reset is released shows a disarmed, quiet block
  a_r1_reset_state: assert property (@(posedge clk) disable iff (hwReset)
    $past(hwReset) |-> (!wdtEnabled && !wdtRstOut));

  // R2: arming only ever follows a write of the second key byte
  a_r2_arm_by_key: assert property (@(posedge clk) disable iff (hwReset)
    $rose(wdtEnabled) |-> $past(keyWr && sfrWdata == KEY_SECOND));

  // R4: without a strobe or a key write the armed count holds
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (hwReset)
    (wdtEnabled && !mcStrobe && !keyWr) |=> ((countNow == $past(countNow)) || wdtRstOut));

  // R5: a pulse starts only from a full counter
  a_r5_pulse_from_top: assert property (@(posedge clk) disable iff (hwReset)
    $rose(wdtRstOut) |-> ($past(&countNow) && $past(wdtEnabled)));

  // R6: during the pulse the block is disarmed with a zero count
  a_r6_held_in_pulse: assert property (@(posedge clk) disable iff (hwReset)
    wdtRstOut |-> (!wdtEnabled && countNow == '0));

  // R8: disarming happens only together with the reset pulse
  a_r8_no_soft_disable: assert property (@(posedge clk) disable iff (hwReset)
    $fell(wdtEnabled) |-> wdtRstOut);

endmodule

bind seq_watchdog seq_watchdog_chk #(
  .CNT_W(CNT_W), .KEY_ADDR(KEY_ADDR), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk(clk), .hwReset(hwReset), .mcStrobe(mcStrobe), .sfrWe(sfrWe),
  .sfrAddr(sfrAddr), .sfrWdata(sfrWdata), .wdtRstOut(wdtRstOut),
  .wdtEnabled(wdtEnabled), .countNow(countNow)
);

// File: tb/sim_seq_watchdog.sv
`timescale 1ns/1ps
module sim_seq_watchdog;

  localparam int PULSE_LEN = 96;
  localparam int TOP       = 16383;
  localparam int WD_LIMIT  = 190000;

  logic       clk = 1'b0;
  logic       hwReset = 1'b1;
  logic       mcStrobe = 1'b0;
  logic       sfrWe = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWdata = 8'h00;
  logic       wdtRstOut, wdtEnabled;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // spec model state
  bit mEn = 0, mFlag = 0;
  int mCnt = 0, mPulse = 0;

  always #10 clk = ~clk;

  seq_watchdog u0 (
    .clk(clk), .hwReset(hwReset), .mcStrobe(mcStrobe), .sfrWe(sfrWe),
    .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .wdtRstOut(wdtRstOut), .wdtEnabled(wdtEnabled)
  );

  function automatic bit isKeyWrite(bit we, logic [7:0] a);
    return we && (a == 8'hA6);
  endfunction

  task automatic modelUpdate(bit we, logic [7:0] a, logic [7:0] d, bit stb, bit hr);
    bit done2;
    if (hr) begin
      mEn = 0; mFlag = 0; mCnt = 0; mPulse = 0;
    end else if (mPulse > 0) begin
      mPulse--; mEn = 0; mFlag = 0; mCnt = 0;
    end else if (mEn && mCnt == TOP) begin
      mPulse = PULSE_LEN; mEn = 0; mFlag = 0; mCnt = 0;
    end else begin
      done2 = isKeyWrite(we, a) && d == 8'hE1 && mFlag;
      if (isKeyWrite(we, a)) mFlag = (d == 8'h1E);
      if (done2) begin mEn = 1; mCnt = 0; end
      else if (mEn && stb) mCnt++;
      else if (!mEn) mCnt = 0;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle (called just after a falling edge), then compare
  task automatic step(bit we, logic [7:0] a, logic [7:0] d, bit stb, bit hr, string tag);
    sfrWe = we; sfrAddr = a; sfrWdata = d; mcStrobe = stb; hwReset = hr;
    @(posedge clk);
    modelUpdate(we, a, d, stb, hr);
    @(negedge clk);
    check(tag, "wdtEnabled", int'(wdtEnabled), int'(mEn));
    check(tag, "wdtRstOut", int'(wdtRstOut), int'(mPulse > 0));
  endtask

  task automatic putKey(string tag);
    step(1, 8'hA6, 8'h1E, 0, 0, tag);
    step(1, 8'hA6, 8'hE1, 0, 0, tag);
  endtask

  task automatic idle(int n, bit stb, string tag);
    for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, stb, 0, tag);
  endtask

  initial begin : watchdog
    while (!done && cycles < WD_LIMIT) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int seedVal;
    int n;
    int highCnt;
    seedVal = $urandom(32'd7731);
    @(negedge clk);
    // R1: reset state
    step(0, 8'h00, 8'h00, 1, 1, "R1");
    step(0, 8'h00, 8'h00, 1, 1, "R1");
    step(0, 8'h00, 8'h00, 1, 0, "R1");

    // R3/R8: disarmed, random non-key traffic must not arm
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 4 == 0) ? 8'hA6 : 8'($urandom);
      d = 8'($urandom);
      if (a == 8'hA6 && (d == 8'h1E || d == 8'hE1)) d = 8'h55;
      step(1, a, d, ($urandom % 12) == 0, 0, "R3");
    end
    // R3: lone 0xE1
    step(1, 8'hA6, 8'hE1, 0, 0, "R3");
    step(0, 8'h00, 8'h00, 0, 0, "R3");
    check("R3", "lone second byte", int'(wdtEnabled), 0);
    // R3: 0x1E, foreign byte at key address, then 0xE1
    step(1, 8'hA6, 8'h1E, 0, 0, "R3");
    step(1, 8'hA6, 8'h77, 0, 0, "R3");
    step(1, 8'hA6, 8'hE1, 0, 0, "R3");
    check("R3", "flag cleared by foreign byte", int'(wdtEnabled), 0);
    // R2/R3: 0x1E, repeated 0x1E, write elsewhere, then 0xE1 arms
    step(1, 8'hA6, 8'h1E, 0, 0, "R2");
    step(1, 8'hA6, 8'h1E, 0, 0, "R3");
    step(1, 8'h80, 8'h00, 0, 0, "R3");
    step(1, 8'hA6, 8'hE1, 0, 0, "R2");
    check("R2", "armed after key", int'(wdtEnabled), 1);

    // R8/R4: random traffic while armed, strobe about one in twelve
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 3 == 0) ? 8'hA6 : 8'($urandom);
      d = ($urandom % 4 == 0) ? (($urandom % 2) ? 8'h1E : 8'hE1) : 8'($urandom);
      step($urandom % 2, a, d, ($urandom % 12) == 0, 0, "R8");
    end
    check("R8", "still armed", int'(wdtEnabled), 1);

    // R7: regular servicing with a strobe every cycle
    putKey("R7");
    for (int r = 0; r < 4; r++) begin
      idle(5000, 1, "R7");
      putKey("R7");
    end
    // R7: key landing one strobe before the top value
    idle(TOP - 1, 1, "R7");
    putKey("R7");
    check("R7", "no pulse after late service", int'(wdtRstOut), 0);

    // R5: unserviced run, pulse after exactly TOP+1 strobe cycles
    n = 0;
    while (!wdtRstOut && n < 20000) begin
      step(0, 8'h00, 8'h00, 1, 0, "R5");
      n++;
    end
    check("R5", "strobe cycles to pulse", n, TOP + 1);
    // R6: pulse width, key writes ignored during pulse
    highCnt = 0;
    while (wdtRstOut && highCnt < 500) begin
      highCnt++;
      step(1, 8'hA6, (highCnt % 2) ? 8'h1E : 8'hE1, 1, 0, "R6");
    end
    check("R6", "pulse width", highCnt, PULSE_LEN);
    idle(200, 1, "R6");
    check("R6", "disarmed after pulse", int'(wdtEnabled), 0);

    // R4: strobe every other cycle, model tracks count via pulse timing
    putKey("R4");
    n = 0;
    while (!wdtRstOut && n < 40000) begin
      step(0, 8'h00, 8'h00, n[0], 0, "R4");
      n++;
    end
    check("R4", "pulse reached at half strobe rate", int'(wdtRstOut), 1);
    idle(PULSE_LEN + 4, 0, "R6");

    // R9: hardware reset in mid pulse
    putKey("R9");
    n = 0;
    while (!wdtRstOut && n < 20000) begin
      step(0, 8'h00, 8'h00, 1, 0, "R9");
      n++;
    end
    idle(10, 1, "R9");
    step(0, 8'h00, 8'h00, 0, 1, "R9");
    check("R9", "pulse ended by reset", int'(wdtRstOut), 0);
    step(0, 8'h00, 8'h00, 0, 0, "R9");
    check("R9", "disarmed after reset", int'(wdtEnabled), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule